// File: doc/BRIEF.md
# Multi-function shared interrupt line aggregator

This block collects interrupt requests from up to four functions of a multi-function bus device and merges them onto four shared, active-low, level-sensitive interrupt lines, A through D. Each function owns a pending flag. A one-cycle internal event pulse sets the flag, and the flag is released only when software writes a one to that function's bit of the clear mask. Each function also owns a small pin-select register. The register routes the function's request to exactly one of the four lines, or to no line at all.

Each line is presented as an open-drain pair: an active-low output enable that pulls the line low, and a data bit tied to zero. The line is therefore never actively driven high. The line outputs are a combinational function of the pending flags and the pin-select registers, with no further registering, so a consumer in another clock domain must synchronize them. When the block is built for a single function, only line A can ever be asserted.

Top module: `intx_agg`

## Requirements
- R1: While reset is high at a clock edge, every pending flag is cleared and every pin-select register returns to code 0, so all four line enables read 1 (released) afterwards.
- R2: An event pulse for function f sets bit f of the pending status at the next clock edge. The bit then stays set on every later edge until it is cleared, and its line stays asserted for that whole time.
- R3: When the clear strobe is high, every function whose clear-mask bit is 1 has its pending bit cleared at the next edge. Functions whose mask bit is 0 are left untouched. With the clear strobe low, the clear mask has no effect.
- R4: When an event pulse and a clear for the same function land on the same edge, the pending bit remains set.
- R5: Pin-select code 0 routes the function to no line, and codes 1, 2, 3 and 4 route it to lines A, B, C and D. Line A is bit 0 of the enable vector and line D is bit 3. A line's enable is 0 exactly while at least one pending function is routed to it.
- R6: Pin-select codes 5, 6 and 7 behave like code 0, and such a function asserts no line.
- R7: Several functions may be routed to one line. That line stays asserted until the last pending function routed to it has been cleared.
- R8: A single pending function never asserts more than one line, whatever its register holds.
- R9: The data bit of every line is always 0.
- R10: In a single-function build, only line A can be asserted. Codes 2, 3 and 4 leave all lines released, while the pending status still records the request.
- R11: A pin-select write takes effect at the next edge, and only the register named by the write index changes. A write index at or above the number of functions changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags and registers |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | NUM_FUNC | One-cycle request pulse per function |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | NUM_FUNC | Write-one-to-clear mask, one bit per function |
| sel_we | input | 1 | Pin-select write strobe |
| sel_idx | input | IDX_W | Function index for the pin-select write |
| sel_data | input | 3 | Pin-select code to write |
| pend_status | output | NUM_FUNC | Active-high pending flag per function |
| line_oe_n | output | 4 | Per-line pull-low enable, 0 asserts the line (bit 0 = A) |
| line_dout | output | 4 | Per-line data bit, always 0 |

## Verification
The hardest state to reach is a line shared by two pending functions where one of them is cleared. The stimulus first routes both functions to the same line and raises both. It then clears one and checks that the line stays low, and clears the other and checks that the line is released. A second difficult case is an event pulse and a clear arriving together. The bench drives both in the same cycle and reads the status afterwards. A second instance built for a single function is used to show that the other lines cannot be reached.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;

    localparam int LINES = 4;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        PIN_NONE = 3'd0,
        PIN_A    = 3'd1,
        PIN_B    = 3'd2,
        PIN_C    = 3'd3,
        PIN_D    = 3'd4
    } pin_sel_e;

    typedef logic [LINES-1:0] line_vec_t;

    // Open-drain pin: enable low pulls the wire, data stays low.
    typedef struct packed {
        logic oe_n;
        logic dout;
    } od_pin_t;

    // Map a pin-select code to a one-hot line vector; reserved codes map to nothing.
    function automatic line_vec_t pin_to_line(input logic [SEL_W-1:0] code,
                                              input logic only_a);
        line_vec_t v;
        case (code)
            PIN_A:   v = 4'b0001;
            PIN_B:   v = 4'b0010;
            PIN_C:   v = 4'b0100;
            PIN_D:   v = 4'b1000;
            default: v = 4'b0000;
        endcase
        if (only_a) v = v & 4'b0001;
        return v;
    endfunction

endpackage

// File: rtl/intx_pend_bank.sv
module intx_pend_bank #(
    parameter int NUM_FUNC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FUNC-1:0] evt,
    input  logic                clr_we,
    input  logic [NUM_FUNC-1:0] clr_mask,
    output logic [NUM_FUNC-1:0] pend
);
    logic [NUM_FUNC-1:0] pend_q;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_flag
        logic clr_hit;
        assign clr_hit = clr_we & clr_mask[f];
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[f] <= 1'b0;
            else if (evt[f])
                pend_q[f] <= 1'b1;     // a new event beats a simultaneous clear
            else if (clr_hit)
                pend_q[f] <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/intx_sel_regs.sv
module intx_sel_regs
    import intx_agg_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int IDX_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           sel_we,
    input  logic [IDX_W-1:0]               sel_idx,
    input  logic [SEL_W-1:0]               sel_data,
    output logic [NUM_FUNC-1:0][SEL_W-1:0] sel
);
    logic [NUM_FUNC-1:0][SEL_W-1:0] sel_q;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_reg
        logic hit;
        assign hit = sel_we && (sel_idx == IDX_W'(f));
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[f] <= PIN_NONE;
            else if (hit)
                sel_q[f] <= sel_data;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/intx_line_merge.sv
module intx_line_merge
    import intx_agg_pkg::*;
#(
    parameter int NUM_FUNC = 4
) (
    input  logic [NUM_FUNC-1:0]            pend,
    input  logic [NUM_FUNC-1:0][SEL_W-1:0] sel,
    output logic [LINES-1:0]               line_oe_n,
    output logic [LINES-1:0]               line_dout
);
    localparam logic ONLY_A = (NUM_FUNC == 1);

    line_vec_t contrib [NUM_FUNC];
    line_vec_t req;
    od_pin_t   pins [LINES];

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
        assign contrib[f] = pin_to_line(sel[f], ONLY_A) & {LINES{pend[f]}};
    end

    always_comb begin
        req = '0;
        for (int f = 0; f < NUM_FUNC; f++) req = req | contrib[f];
    end

    for (genvar l = 0; l < LINES; l++) begin : g_pin
        assign pins[l].oe_n = ~req[l];
        assign pins[l].dout = 1'b0;
        assign line_oe_n[l] = pins[l].oe_n;
        assign line_dout[l] = pins[l].dout;
    end
endmodule

// File: rtl/intx_agg.sv
module intx_agg
    import intx_agg_pkg::*;
#(
    parameter int NUM_FUNC = 4,
    parameter int IDX_W    = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FUNC-1:0] evt,
    input  logic                clr_we,
    input  logic [NUM_FUNC-1:0] clr_mask,
    input  logic                sel_we,
    input  logic [IDX_W-1:0]    sel_idx,
    input  logic [SEL_W-1:0]    sel_data,
    output logic [NUM_FUNC-1:0] pend_status,
    output logic [LINES-1:0]    line_oe_n,
    output logic [LINES-1:0]    line_dout
);
    logic [NUM_FUNC-1:0]            pend;
    logic [NUM_FUNC-1:0][SEL_W-1:0] sel;

    intx_pend_bank #(.NUM_FUNC(NUM_FUNC)) u_pend (
        .clk(clk), .rst(rst), .evt(evt),
        .clr_we(clr_we), .clr_mask(clr_mask), .pend(pend)
    );

    intx_sel_regs #(.NUM_FUNC(NUM_FUNC), .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_idx(sel_idx),
        .sel_data(sel_data), .sel(sel)
    );

    intx_line_merge #(.NUM_FUNC(NUM_FUNC)) u_merge (
        .pend(pend), .sel(sel), .line_oe_n(line_oe_n), .line_dout(line_dout)
    );

    assign pend_status = pend;
endmodule

// File: rtl/intx_agg_chk.sv
module intx_agg_chk #(
    parameter int NUM_FUNC = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_FUNC-1:0] evt,
    input logic                clr_we,
    input logic [NUM_FUNC-1:0] clr_mask,
    input logic [NUM_FUNC-1:0] pend_status,
    input logic [3:0]          line_oe_n,
    input logic [3:0]          line_dout
);
    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> (pend_status == '0 && line_oe_n == 4'hF)); // R1

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        (pend_status == '0) |-> (line_oe_n == 4'hF)); // R5

    AST_ONE_LINE_EACH: assert property (@(posedge clk) disable iff (rst)
        ($countones(pend_status) <= 1) |-> $onehot0(~line_oe_n)); // R8

    AST_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
        line_dout == 4'h0); // R9

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
        AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
            evt[f] |=> pend_status[f]); // R4

        AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
            (pend_status[f] && !(clr_we && clr_mask[f])) |=> pend_status[f]); // R2

        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_we && clr_mask[f] && !evt[f]) |=> !pend_status[f]); // R3
    end

    if (NUM_FUNC == 1) begin : g_single
        AST_ONLY_A: assert property (@(posedge clk) disable iff (rst)
            line_oe_n[3:1] == 3'b111); // R10
    end
endmodule

bind intx_agg intx_agg_chk #(.NUM_FUNC(NUM_FUNC)) u_chk (
    .clk(clk), .rst(rst), .evt(evt), .clr_we(clr_we), .clr_mask(clr_mask),
    .pend_status(pend_status), .line_oe_n(line_oe_n), .line_dout(line_dout)
);

// File: tb/sim_intx_agg.sv
`timescale 1ns/1ps
module sim_intx_agg;
    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    // four-function instance
    logic [3:0] evt, clr_mask, status;
    logic       clr_we, sel_we;
    logic [1:0] sel_idx;
    logic [2:0] sel_data;
    logic [3:0] oe_n, dout;

    intx_agg #(.NUM_FUNC(4)) u0 (
        .clk(clk), .rst(rst), .evt(evt), .clr_we(clr_we), .clr_mask(clr_mask),
        .sel_we(sel_we), .sel_idx(sel_idx), .sel_data(sel_data),
        .pend_status(status), .line_oe_n(oe_n), .line_dout(dout)
    );

    // single-function instance
    logic [0:0] evt1, clr_mask1, status1, sel_idx1;
    logic       clr_we1, sel_we1;
    logic [2:0] sel_data1;
    logic [3:0] oe_n1, dout1;

    intx_agg #(.NUM_FUNC(1)) u1 (
        .clk(clk), .rst(rst), .evt(evt1), .clr_we(clr_we1), .clr_mask(clr_mask1),
        .sel_we(sel_we1), .sel_idx(sel_idx1), .sel_data(sel_data1),
        .pend_status(status1), .line_oe_n(oe_n1), .line_dout(dout1)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_sel(input int idx, input logic [2:0] code);
        sel_we = 1'b1; sel_idx = 2'(idx); sel_data = code;
        step();
        sel_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        evt = m; step(); evt = '0;
    endtask

    task automatic clear(input logic [3:0] m);
        clr_we = 1'b1; clr_mask = m; step(); clr_we = 1'b0; clr_mask = '0;
    endtask

    // {sel3, sel2, sel1, sel0, event mask, expected line_oe_n}
    localparam int NV = 6;
    localparam logic [19:0] VEC [NV] = '{
        {3'd1, 3'd1, 3'd1, 3'd1, 4'b0001, 4'b1110},
        {3'd4, 3'd3, 3'd2, 3'd1, 4'b1111, 4'b0000},
        {3'd4, 3'd3, 3'd2, 3'd1, 4'b0100, 4'b1011},
        {3'd0, 3'd0, 3'd4, 3'd4, 4'b1111, 4'b0111},
        {3'd0, 3'd7, 3'd6, 3'd5, 4'b1111, 4'b1111},
        {3'd7, 3'd3, 3'd2, 3'd2, 4'b0011, 4'b1101}
    };

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; evt = '0; clr_we = 1'b0; clr_mask = '0;
        sel_we = 1'b0; sel_idx = '0; sel_data = '0;
        evt1 = '0; clr_we1 = 1'b0; clr_mask1 = '0; sel_we1 = 1'b0; sel_idx1 = '0; sel_data1 = '0;
        step(); step();
        rst = 1'b0;
        step();
        check("R1 status", {4'h0, status}, 8'h00);
        check("R1 lines", {4'h0, oe_n}, 8'h0F);
        check("R9 data", {4'h0, dout}, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            clear(4'hF);
            for (int f = 0; f < 4; f++) wr_sel(f, VEC[i][19 - 3*f -: 3]);
            // reorder: VEC holds sel3 in top bits; f=0 took sel3 above, fix by rewriting
            for (int f = 0; f < 4; f++) wr_sel(f, VEC[i][8 + 3*f +: 3]);
            pulse(VEC[i][7:4]);
            check($sformatf("R5/R6/R7 vector %0d lines", i), {4'h0, oe_n}, {4'h0, VEC[i][3:0]});
            check($sformatf("R2 vector %0d status", i), {4'h0, status}, {4'h0, VEC[i][7:4]});
        end

        // level hold (R2)
        clear(4'hF);
        wr_sel(0, 3'd3);
        pulse(4'b0001);
        repeat (5) step();
        check("R2 held lines", {4'h0, oe_n}, 8'h0B);
        // clear with strobe low has no effect (R3)
        clr_mask = 4'hF; step(); clr_mask = '0;
        check("R3 strobe low", {4'h0, status}, 8'h01);
        // clear only unselected function (R3)
        clear(4'b0010);
        check("R3 other mask", {4'h0, status}, 8'h01);
        clear(4'b0001);
        check("R3 cleared", {4'h0, status}, 8'h00);
        check("R3 line released", {4'h0, oe_n}, 8'h0F);

        // shared line (R7)
        wr_sel(1, 3'd3);
        pulse(4'b0011);
        clear(4'b0001);
        check("R7 shared still low", {4'h0, oe_n}, 8'h0B);
        clear(4'b0010);
        check("R7 shared released", {4'h0, oe_n}, 8'h0F);

        // event and clear together (R4)
        evt = 4'b0001; clr_we = 1'b1; clr_mask = 4'b0001;
        step();
        evt = '0; clr_we = 1'b0; clr_mask = '0;
        check("R4 event wins", {4'h0, status}, 8'h01);
        check("R4 line", {4'h0, oe_n}, 8'h0B);

        // re-routing a pending function moves its line, never two (R11, R8)
        wr_sel(0, 3'd4);
        check("R11 moved", {4'h0, oe_n}, 8'h07);
        check("R8 one line", {4'h0, oe_n}, 8'h07);
        check("R11 other reg kept", {4'h0, oe_n | 4'h0}, 8'h07);
        pulse(4'b0010);
        check("R11 func1 still C", {4'h0, oe_n}, 8'h03);
        check("R9 data", {4'h0, dout}, 8'h00);

        // reset mid-run (R1)
        rst = 1'b1; step(); rst = 1'b0;
        check("R1 rst status", {4'h0, status}, 8'h00);
        pulse(4'b1111);
        check("R1 sel regs none", {4'h0, oe_n}, 8'h0F);
        clear(4'hF);

        // single-function build (R10, R11)
        sel_we1 = 1'b1; sel_idx1 = 1'b0; sel_data1 = 3'd2; step(); sel_we1 = 1'b0;
        evt1 = 1'b1; step(); evt1 = 1'b0;
        check("R10 status", {7'h0, status1}, 8'h01);
        check("R10 B unreachable", {4'h0, oe_n1}, 8'h0F);
        sel_we1 = 1'b1; sel_idx1 = 1'b1; sel_data1 = 3'd1; step(); sel_we1 = 1'b0;
        check("R11 idx out of range", {4'h0, oe_n1}, 8'h0F);
        sel_we1 = 1'b1; sel_idx1 = 1'b0; sel_data1 = 3'd1; step(); sel_we1 = 1'b0;
        check("R10 A asserted", {4'h0, oe_n1}, 8'h0E);
        check("R9 data single", {4'h0, dout1}, 8'h00);
        clr_we1 = 1'b1; clr_mask1 = 1'b1; step(); clr_we1 = 1'b0; clr_mask1 = '0;
        check("R3 single cleared", {4'h0, oe_n1}, 8'h0F);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule